// File: doc/BRIEF.md
# Byte-Addressed I2C Register Target with Bus Timeout

This block is an I2C target that answers on one fixed 7-bit device address. It gives a host byte-wide access to a 256-location register space. SCL and SDA are sampled on the system clock through a two-stage synchronizer. The block finds START and STOP conditions and shifts bytes in and out, MSB first. It acknowledges by pulling SDA low through an open-drain enable.

In a write transfer, the first byte after the device address loads an internal location pointer. Each later byte is handed to an external register-file write port at the pointer, and the pointer then advances. A read transfer returns bytes from an asynchronous read port, starting at the pointer and advancing it after every byte sent. The pointer wraps from FFh to 00h. It keeps its value between transfers, so a read that sends no location byte carries on from where the previous transfer stopped. The upper locations act as plain storage; the block treats every location the same way.

A watchdog counts system clocks while SCL is low and a transfer is in progress. When the count reaches its limit, the protocol engine drops back to idle and releases SDA. A byte that has not yet reached its acknowledge clock is then thrown away. A host recovers by clocking SCL until SDA reads high and then issuing a fresh START.

Top module: `i2c_regslave`

## Requirements
- R1: A byte after START whose upper seven bits equal DEV_ADDR (default 7'h68) is acknowledged by pulling SDA low for the ninth clock; bit 0 selects read (1) or write (0). Any other address gets no acknowledge, and SDA stays released until the next START.
- R2: In a write transfer, the first byte after the address loads the location pointer. Every later byte is written to the pointer location, which then advances by one. Every such byte is acknowledged.
- R3: A received data byte is committed only at the SCL rising edge of its acknowledge clock, as a `wrEn` pulse exactly one system clock wide.
- R4: In a read transfer, bytes are shifted out MSB first from `rdData` at `rdAddr` = pointer, and the pointer advances after each byte. A master acknowledge (SDA low on the ninth clock) starts the next byte.
- R5: The pointer wraps from FFh to 00h on both reads and writes.
- R6: The pointer keeps its value across STOP, so a read transfer without a location byte starts from the location after the last byte transferred.
- R7: After a master not-acknowledge, the target releases SDA and ignores all clocks until STOP or START.
- R8: A repeated START at any point abandons the byte in progress (nothing is committed) and restarts address reception.
- R9: STOP returns the target to idle; bits clocked after it without a new START get no acknowledge.
- R10: If SCL stays low for TIMEOUT_CYCLES system clocks during a transfer, the target goes idle and releases SDA. A byte not yet at its acknowledge clock is not committed, even if all eight bits were received.
- R11: After a timeout, a fresh START followed by a normal write transfer works.
- R12: The target changes its SDA drive only while SCL is low.
- R13: Out of reset, SDA is released and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it |
| rdAddr | output | 8 | Read-port location (current pointer) |
| rdData | input | 8 | Read-port data, valid in the same cycle as rdAddr |
| wrEn | output | 1 | One-cycle write strobe |
| wrAddr | output | 8 | Write location |
| wrData | output | 8 | Write data |

## Verification
A corrupted pointer shows up at the ports as a wrong byte: on the first read in the next transfer, or as a write to the wrong location at the next acknowledge. Sweeps across the FFh/00h wrap catch it within one byte time. A protocol state machine that ends up in the wrong state either leaves an acknowledge out or pulls SDA low when it should not. A monitor on `sdaDriveLow` against SCL catches this at the first SCL edge. Timeout faults are caught by holding SCL low in three different phases: mid-byte, before the acknowledge, and while driving read data. The checks then look at SDA release, at the external storage, and at whether the next START is accepted.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_WORD, S_DATA,
    S_ACK_A, S_ACK_W, S_ACK_D,
    S_TX, S_MACK, S_WAIT
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
    logic commit;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_regslave_ctrl.sv
module i2c_regslave_ctrl
  import i2c_regslave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR       = 7'h68,
  parameter int         TIMEOUT_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         strb,
  output logic              sdaBit,
  output logic              sdaDriveLow
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CYCLES);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow;
  logic       sclRise, sclFall, busStart, busStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow   = sclSync[1];
  assign sdaNow   = sdaSync[1];
  assign sdaBit   = sdaNow;
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign busStart = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign busStop  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  busState_t        st, stNext;
  logic [2:0]       bitCnt, bitNext;
  logic             done, doneNext;
  logic             rwBit, rwNext;
  logic [CNT_W-1:0] tmoCnt;
  logic             tmoHit;

  assign tmoHit = (tmoCnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmoCnt <= '0;
    else if (st == S_IDLE || sclNow || tmoHit) tmoCnt <= '0;
    else tmoCnt <= tmoCnt + 1'b1;
  end

  always_comb begin
    stNext   = st;
    bitNext  = bitCnt;
    doneNext = done;
    rwNext   = rwBit;
    strb     = '0;
    if (tmoHit) begin
      stNext   = S_IDLE;
      doneNext = 1'b0;
    end else if (busStart) begin
      stNext   = S_ADDR;
      bitNext  = '0;
      doneNext = 1'b0;
    end else if (busStop) begin
      stNext   = S_IDLE;
      doneNext = 1'b0;
    end else begin
      unique case (st)
        S_ADDR, S_WORD, S_DATA: begin
          if (sclRise && !done) begin
            strb.shiftIn = 1'b1;
            bitNext      = bitCnt + 3'd1;
            doneNext     = (bitCnt == 3'd7);
          end else if (sclFall && done) begin
            doneNext = 1'b0;
            if (st == S_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stNext = S_ACK_A;
                rwNext = rxByte[0];
              end else begin
                stNext = S_WAIT;
              end
            end else if (st == S_WORD) begin
              stNext = S_ACK_W;
            end else begin
              stNext = S_ACK_D;
            end
          end
        end
        S_ACK_A: if (sclFall) begin
          bitNext = '0;
          if (rwBit) begin
            stNext       = S_TX;
            strb.loadTx  = 1'b1;
          end else begin
            stNext = S_WORD;
          end
        end
        S_ACK_W: if (sclFall) begin
          strb.loadPtr = 1'b1;
          bitNext      = '0;
          stNext       = S_DATA;
        end
        S_ACK_D: begin
          if (sclRise) begin
            strb.commit = 1'b1;
            strb.incPtr = 1'b1;
          end else if (sclFall) begin
            bitNext = '0;
            stNext  = S_DATA;
          end
        end
        S_TX: begin
          if (sclRise && !done) begin
            bitNext  = bitCnt + 3'd1;
            doneNext = (bitCnt == 3'd7);
          end else if (sclFall) begin
            if (done) begin
              doneNext    = 1'b0;
              strb.incPtr = 1'b1;
              stNext      = S_MACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        S_MACK: begin
          if (sclRise && sdaNow) begin
            stNext = S_WAIT;
          end else if (sclFall) begin
            stNext      = S_TX;
            strb.loadTx = 1'b1;
            bitNext     = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= S_IDLE;
      bitCnt <= '0;
      done   <= 1'b0;
      rwBit  <= 1'b0;
    end else begin
      st     <= stNext;
      bitCnt <= bitNext;
      done   <= doneNext;
      rwBit  <= rwNext;
    end
  end

  assign sdaDriveLow = (st inside {S_ACK_A, S_ACK_W, S_ACK_D}) | ((st == S_TX) & ~txBit);

  // R12: drive level moves only during SCL low
  a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclNow);
  // R10: a timeout leaves the engine idle with SDA released
  a_r10_timeout_idle: assert property (@(posedge clk) disable iff (!rstN)
    tmoHit |=> (st == S_IDLE) && !sdaDriveLow);
  // R10: the counter never passes its limit
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    tmoCnt <= CNT_MAX);
  // R9: STOP ends the transfer
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    busStop && !tmoHit |=> st == S_IDLE);
  // R8: START restarts address reception from bit zero
  a_r8_restart_addr: assert property (@(posedge clk) disable iff (!rstN)
    busStart && !tmoHit |=> (st == S_ADDR) && (bitCnt == 3'd0));
endmodule

// File: rtl/i2c_regslave_dp.sv
module i2c_regslave_dp
  import i2c_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic [PTR_W-1:0]  ptr,
  output logic              wrEn,
  output logic [PTR_W-1:0]  wrAddr,
  output logic [BYTE_W-1:0] wrData
);
  logic [BYTE_W-1:0] rxSr, txSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr   <= '0;
      txSr   <= '1;
      ptr    <= '0;
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= strb.commit;
      if (strb.commit) begin
        wrAddr <= ptr;
        wrData <= rxSr;
      end
      if (strb.shiftIn) rxSr <= {rxSr[BYTE_W-2:0], sdaBit};
      if (strb.loadTx) txSr <= rdData;
      else if (strb.shiftTx) txSr <= {txSr[BYTE_W-2:0], 1'b1};
      if (strb.loadPtr) ptr <= rxSr[PTR_W-1:0];
      else if (strb.incPtr) ptr <= ptr + 1'b1;
    end
  end

  assign rxByte = rxSr;
  assign txBit  = txSr[BYTE_W-1];

  // R5: advancing from the top location lands on zero
  a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.incPtr && !strb.loadPtr && (ptr == '1) |=> ptr == '0);
  // R3: each commit is a single-cycle write strobe
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_regslave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR       = 7'h68,
  parameter int         TIMEOUT_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic [PTR_W-1:0]  rdAddr,
  input  logic [BYTE_W-1:0] rdData,
  output logic              wrEn,
  output logic [PTR_W-1:0]  wrAddr,
  output logic [BYTE_W-1:0] wrData
);
  dpStrobe_t         strb;
  logic              sdaBit, txBit;
  logic [BYTE_W-1:0] rxByte;

  i2c_regslave_ctrl #(.DEV_ADDR(DEV_ADDR), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .strb(strb),
    .sdaBit(sdaBit), .sdaDriveLow(sdaDriveLow)
  );

  i2c_regslave_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit), .rdData(rdData),
    .rxByte(rxByte), .txBit(txBit), .ptr(rdAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: tb/i2c_regslave_tb_top.sv
`timescale 1ns/1ps
module i2c_regslave_tb_top;
  localparam int HALF = 10;
  localparam int TMO  = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclOut = 1'b1;
  logic mLow = 1'b0;
  logic sdaDriveLow, wrEn;
  logic [7:0] rdAddr, wrAddr, wrData, rdData;
  logic sdaBus;

  logic [7:0] mem [256];
  logic [7:0] expMem [256];

  int nChecks = 0, nErr = 0;
  int wrCount = 0, dblWr = 0, sclViol = 0, driveCnt = 0;
  logic prevDrive = 1'b0, prevWr = 1'b0;

  always #5 clk = ~clk;

  assign sdaBus = !(mLow || sdaDriveLow);
  assign rdData = mem[rdAddr];

  i2c_regslave #(.DEV_ADDR(7'h68), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclOut), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  function automatic logic [7:0] initVal(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] sweepVal(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= initVal(i);
    end else if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (sdaDriveLow != prevDrive && sclOut) sclViol++;
      if (wrEn && prevWr) dblWr++;
      if (wrEn) wrCount++;
      if (sdaDriveLow) driveCnt++;
    end
    prevDrive <= sdaDriveLow;
    prevWr    <= wrEn;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clkWait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    clkWait(2); mLow = 1'b0; clkWait(HALF); sclOut = 1'b1;
    clkWait(HALF); mLow = 1'b1; clkWait(HALF); sclOut = 1'b0;
  endtask

  task automatic stopCond();
    clkWait(2); mLow = 1'b1; clkWait(HALF); sclOut = 1'b1;
    clkWait(HALF); mLow = 1'b0; clkWait(HALF);
  endtask

  task automatic sendBit(bit b);
    clkWait(2); mLow = !b; clkWait(HALF); sclOut = 1'b1;
    clkWait(HALF); sclOut = 1'b0;
  endtask

  task automatic recvBit(output bit b);
    clkWait(2); mLow = 1'b0; clkWait(HALF); sclOut = 1'b1;
    clkWait(HALF / 2); b = sdaBus; clkWait(HALF - HALF / 2); sclOut = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = !b;
  endtask

  task automatic recvByte(bit giveAck, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(!giveAck);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    int w0, d0;
    for (int i = 0; i < 256; i++) expMem[i] = initVal(i);
    clkWait(5);
    rstN = 1'b1;
    clkWait(5);

    // R13 reset state
    check(sdaDriveLow == 1'b0, "R13", "sda released", int'(sdaDriveLow), 0);
    check(wrCount == 0, "R13", "no write", wrCount, 0);

    // R1 foreign address ignored
    d0 = driveCnt; w0 = wrCount;
    startCond();
    sendByte(8'hA0, ack);
    check(!ack, "R1", "foreign addr ack", int'(ack), 0);
    sendByte(8'h00, ack);
    stopCond();
    check(driveCnt == d0, "R1", "drive after foreign addr", driveCnt - d0, 0);
    check(wrCount == w0, "R1", "writes after foreign addr", wrCount - w0, 0);

    // R2 R5 write sweep across the wrap
    w0 = wrCount;
    startCond();
    sendByte(8'hD0, ack);
    check(ack, "R1", "own addr write ack", int'(ack), 1);
    sendByte(8'hE0, ack);
    check(ack, "R2", "location byte ack", int'(ack), 1);
    for (int i = 0; i < 64; i++) begin
      sendByte(sweepVal(i), ack);
      check(ack, "R2", "data ack", int'(ack), 1);
      expMem[(8'hE0 + i) & 255] = sweepVal(i);
    end
    stopCond();
    clkWait(4);
    for (int i = 0; i < 256; i++)
      check(mem[i] == expMem[i], "R5", "stored byte after sweep", int'(mem[i]), int'(expMem[i]));
    check(wrCount - w0 == 64, "R3", "write pulse count", wrCount - w0, 64);
    check(dblWr == 0, "R3", "double-wide write", dblWr, 0);

    // R4 R5 R8 read sweep via repeated START
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'hE0, ack);
    startCond();
    sendByte(8'hD1, ack);
    check(ack, "R8", "read addr ack after restart", int'(ack), 1);
    for (int i = 0; i < 64; i++) begin
      recvByte(i != 63, v);
      check(v == expMem[(8'hE0 + i) & 255], "R4", "read data", int'(v), int'(expMem[(8'hE0 + i) & 255]));
    end
    stopCond();

    // R6 pointer carried over, R7 ignore after NACK
    startCond();
    sendByte(8'hD1, ack);
    recvByte(1'b0, v);
    check(v == expMem[8'h20], "R6", "read continues at pointer", int'(v), int'(expMem[8'h20]));
    d0 = driveCnt;
    sendByte(8'h00, ack);
    check(driveCnt == d0, "R7", "drive after NACK", driveCnt - d0, 0);
    stopCond();

    // R8 repeated START mid-byte discards the byte
    w0 = wrCount;
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h05, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    startCond();
    sendByte(8'hD1, ack);
    recvByte(1'b0, v);
    stopCond();
    check(v == expMem[8'h05], "R8", "aborted byte not stored", int'(v), int'(expMem[8'h05]));
    check(wrCount == w0, "R8", "no write on abort", wrCount - w0, 0);

    // R9 no response after STOP without START
    sendByte(8'hD0, ack);
    check(!ack, "R9", "ack without START", int'(ack), 0);
    stopCond();

    // R10 timeout mid-byte, R11 recovery
    w0 = wrCount;
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h10, ack);
    for (int i = 0; i < 4; i++) sendBit(i[0]);
    clkWait(TMO + 40);
    check(sdaDriveLow == 1'b0, "R10", "sda released after timeout", int'(sdaDriveLow), 0);
    check(wrCount == w0, "R10", "no write on mid-byte timeout", wrCount - w0, 0);
    check(mem[8'h10] == expMem[8'h10], "R10", "location untouched", int'(mem[8'h10]), int'(expMem[8'h10]));
    startCond();
    sendByte(8'hD0, ack);
    check(ack, "R11", "addr ack after timeout", int'(ack), 1);
    sendByte(8'h11, ack);
    sendByte(8'h3C, ack);
    stopCond();
    expMem[8'h11] = 8'h3C;
    clkWait(3);
    check(mem[8'h11] == 8'h3C, "R11", "write after recovery", int'(mem[8'h11]), 8'h3C);

    // R10 timeout with a full byte waiting for its acknowledge clock
    w0 = wrCount;
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h12, ack);
    for (int i = 7; i >= 0; i--) sendBit(1'(8'h77 >> i));
    clkWait(6);
    check(sdaDriveLow == 1'b1, "R2", "ack being driven", int'(sdaDriveLow), 1);
    clkWait(TMO + 40);
    check(sdaDriveLow == 1'b0, "R10", "ack released by timeout", int'(sdaDriveLow), 0);
    check(wrCount == w0, "R10", "no write before ack clock", wrCount - w0, 0);
    check(mem[8'h12] == expMem[8'h12], "R10", "full byte discarded", int'(mem[8'h12]), int'(expMem[8'h12]));

    // R10 timeout while driving read data (location 30h holds a byte with MSB 0)
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h30, ack);
    startCond();
    sendByte(8'hD1, ack);
    clkWait(6);
    check(sdaDriveLow == 1'b1, "R4", "MSB first driven low", int'(sdaDriveLow), 1);
    clkWait(TMO + 40);
    check(sdaDriveLow == 1'b0, "R10", "read drive released", int'(sdaDriveLow), 0);
    startCond();
    stopCond();

    check(sclViol == 0, "R12", "sda changed with SCL high", sclViol, 0);
    check(dblWr == 0, "R3", "double-wide write", dblWr, 0);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule